// File: doc/BRIEF.md
# Hashed MAC Address Lookup Table

This block is the forwarding lookup of an Ethernet switch. Given a 48-bit destination MAC address, it returns whether the address is known and, if so, the output port it was learned on. The key is hashed with a CRC-16 to pick one of a fixed number of buckets. Every bucket heads a singly linked chain of entries, and all entries come from one shared on-chip pool. A lookup walks its bucket's chain and compares one entry per cycle, so the time to an answer depends on where the key sits in the chain.

Learning uses a separate insert request. If the address is already in the table, its port is rewritten in place. Otherwise a fresh entry is taken from the pool and linked in at the front of the bucket's chain. Lookups and inserts share a single engine, and only one operation is in progress at a time. While `busy` is high, new requests are ignored. Each operation ends with a one-cycle done pulse that carries its result.

Top module: `mac_hash_lookup`

## Requirements
- R1: After reset, `busy`, `lkp_done`, `ins_done` and `ins_err` are low, and every lookup misses.
- R2: The bucket is bits [BKT_W-1:0] of a CRC-16 over the key. The CRC uses polynomial 0x8005, initial value 0, key bit 47 first, no reflection and no final inversion. Keys whose buckets are equal share one chain.
- R3: A lookup of a stored key raises `lkp_done` with `lkp_hit`=1 and the stored port. Accept the request at a rising edge with `busy` low. Then `lkp_done` is high for exactly one cycle after the (1+j)-th following rising edge, where j is the key's position in its chain and the most recently inserted key is position 1.
- R4: A lookup of an absent key whose bucket holds L>0 entries returns `lkp_hit`=0 with latency 1+L.
- R5: A lookup whose bucket is empty returns a miss with latency 1 and reads no entry.
- R6: An insert of a new key sets `ins_done` with `ins_err`=0 and makes the key findable at chain position 1.
- R7: An insert of a key already stored replaces its port, keeps its chain position and uses no pool entry. This still holds when the pool is full.
- R8: An insert of a new key while all ENTRIES pool entries are used sets `ins_done` with `ins_err`=1 and leaves the table unchanged.
- R9: While `busy` is high, lookup and insert requests are ignored and produce no done pulse.
- R10: When both requests are valid in the same idle cycle, the lookup is taken and the insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_key | input | 48 | MAC address to look up |
| ins_valid | input | 1 | Insert request |
| ins_key | input | 48 | MAC address to learn |
| ins_port | input | PORT_W | Port to associate |
| busy | output | 1 | Engine occupied; requests ignored |
| lkp_done | output | 1 | One-cycle lookup result strobe |
| lkp_hit | output | 1 | Key found (valid with lkp_done) |
| lkp_port | output | PORT_W | Port of found key |
| ins_done | output | 1 | One-cycle insert completion strobe |
| ins_err | output | 1 | Insert rejected, pool full (with ins_done) |

## Verification
Lookups of absent keys are made early, against partly filled buckets, so that both empty-bucket misses and chain-end misses occur. Their latencies tell apart the fixed minimum path and a full chain walk. Once the pool is filled, every stored key is looked up. The measured cycle count must match the chain position, which the bench derives from its own CRC and insertion order. This confirms both the hash and the push-at-head ordering. The bench also applies requests while the engine is busy, requests of both kinds in the same cycle, a rewrite at full occupancy and an over-capacity insert. These show whether the arbitration, the rewrite-in-place and the rejection rule each leave the table as stated.

// File: rtl/mac_hash_lookup.sv
module mac_hash_lookup #(
  parameter int KEY_W   = 48,
  parameter int PORT_W  = 4,
  parameter int BUCKETS = 64,
  parameter int ENTRIES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [KEY_W-1:0]  lkp_key,
  input  logic              ins_valid,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [PORT_W-1:0] ins_port,
  output logic              busy,
  output logic              lkp_done,
  output logic              lkp_hit,
  output logic [PORT_W-1:0] lkp_port,
  output logic              ins_done,
  output logic              ins_err
);
  localparam int BKT_W = $clog2(BUCKETS);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_LHEAD, S_LWALK, S_IHEAD, S_IWALK} state_t;

  function automatic logic [15:0] crc16(input logic [KEY_W-1:0] k);
    logic [15:0] c;
    logic        fb;
    c = '0;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      fb = c[15] ^ k[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  state_t              state;
  logic [KEY_W-1:0]    op_key;
  logic [PORT_W-1:0]   op_port;
  logic [BKT_W-1:0]    op_bkt;
  logic [PTR_W-1:0]    ptr;
  logic [CNT_W-1:0]    pool_cnt;
  logic [BUCKETS-1:0]  head_vld;
  logic [PTR_W-1:0]    head_ptr [BUCKETS];
  logic [KEY_W-1:0]    e_key    [ENTRIES];
  logic [PORT_W-1:0]   e_port   [ENTRIES];
  logic [PTR_W-1:0]    e_next   [ENTRIES];
  logic [ENTRIES-1:0]  e_nvld;

  wire              idle      = (state == S_IDLE);
  wire              start_lkp = idle && lkp_valid;
  wire              start_ins = idle && ins_valid && !lkp_valid;
  wire [KEY_W-1:0]  sel_key   = lkp_valid ? lkp_key : ins_key;
  wire [15:0]       sel_crc   = crc16(sel_key);
  wire              full      = (pool_cnt == CNT_W'(ENTRIES));
  wire              bkt_live  = head_vld[op_bkt];
  wire              cur_match = (e_key[ptr] == op_key);
  wire              cur_more  = e_nvld[ptr];
  wire [PTR_W-1:0]  new_idx   = pool_cnt[PTR_W-1:0];

  wire need_alloc = ((state == S_IHEAD) && !bkt_live) ||
                    ((state == S_IWALK) && !cur_match && !cur_more);
  wire alloc_we   = need_alloc && !full;
  wire upd_we     = (state == S_IWALK) && cur_match;

  assign busy = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_key   <= '0;
      op_port  <= '0;
      op_bkt   <= '0;
      ptr      <= '0;
      pool_cnt <= '0;
      head_vld <= '0;
      lkp_done <= 1'b0;
      lkp_hit  <= 1'b0;
      lkp_port <= '0;
      ins_done <= 1'b0;
      ins_err  <= 1'b0;
    end else begin
      lkp_done <= 1'b0;
      lkp_hit  <= 1'b0;
      ins_done <= 1'b0;
      ins_err  <= 1'b0;
      if (alloc_we) begin
        pool_cnt         <= pool_cnt + 1'b1;
        head_vld[op_bkt] <= 1'b1;
      end
      case (state)
        S_IDLE: begin
          if (start_lkp || start_ins) begin
            op_key  <= sel_key;
            op_port <= ins_port;
            op_bkt  <= sel_crc[BKT_W-1:0];
            state   <= start_lkp ? S_LHEAD : S_IHEAD;
          end
        end
        S_LHEAD: begin
          if (bkt_live) begin
            ptr   <= head_ptr[op_bkt];
            state <= S_LWALK;
          end else begin
            lkp_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_LWALK: begin
          if (cur_match) begin
            lkp_done <= 1'b1;
            lkp_hit  <= 1'b1;
            lkp_port <= e_port[ptr];
            state    <= S_IDLE;
          end else if (cur_more) begin
            ptr <= e_next[ptr];
          end else begin
            lkp_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_IHEAD: begin
          if (bkt_live) begin
            ptr   <= head_ptr[op_bkt];
            state <= S_IWALK;
          end else begin
            ins_done <= 1'b1;
            ins_err  <= full;
            state    <= S_IDLE;
          end
        end
        S_IWALK: begin
          if (cur_match) begin
            ins_done <= 1'b1;
            state    <= S_IDLE;
          end else if (cur_more) begin
            ptr <= e_next[ptr];
          end else begin
            ins_done <= 1'b1;
            ins_err  <= full;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      e_key[new_idx]   <= op_key;
      e_port[new_idx]  <= op_port;
      e_next[new_idx]  <= head_ptr[op_bkt];
      e_nvld[new_idx]  <= bkt_live;
      head_ptr[op_bkt] <= new_idx;
    end
    if (upd_we) e_port[ptr] <= op_port;
  end

  assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_done && ins_done));

  assert_hit_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> lkp_done);

  assert_err_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> (ins_done && pool_cnt == CNT_W'(ENTRIES)));

  assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (lkp_valid || ins_valid)) |=> busy);

  assert_empty_bucket_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LHEAD && !bkt_live) |=> (lkp_done && !lkp_hit && !busy));

  assert_pool_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pool_cnt <= CNT_W'(ENTRIES));
endmodule

// File: tb/tb_mac_hash_lookup.sv
module tb_mac_hash_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 4;
  localparam int BUCKETS = 64;
  localparam int ENTRIES = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 1'b0, ins_valid = 1'b0;
  logic [47:0] lkp_key = '0, ins_key = '0;
  logic [PORT_W-1:0] ins_port = '0;
  logic busy, lkp_done, lkp_hit, ins_done, ins_err;
  logic [PORT_W-1:0] lkp_port;

  mac_hash_lookup #(.KEY_W(48), .PORT_W(PORT_W), .BUCKETS(BUCKETS), .ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_key(lkp_key),
    .ins_valid(ins_valid), .ins_key(ins_key), .ins_port(ins_port),
    .busy(busy), .lkp_done(lkp_done), .lkp_hit(lkp_hit), .lkp_port(lkp_port),
    .ins_done(ins_done), .ins_err(ins_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int n_ins = 0;
  int m_id   [ENTRIES];
  int m_bkt  [ENTRIES];
  int m_port [ENTRIES];

  function automatic logic [47:0] key_of(input int i);
    logic [31:0] lo;
    lo = 32'(i) * 32'h9E3779B1;
    return {16'hA5C3 ^ 16'(i * 7), lo};
  endfunction

  // R2: remainder of key * x^16 divided by x^16 + x^15 + x^2 + 1
  function automatic int bucket_of(input logic [47:0] k);
    logic [63:0] d;
    d = {k, 16'h0};
    for (int b = 63; b >= 16; b--)
      if (d[b]) d[b -: 17] = d[b -: 17] ^ 17'h18005;
    return int'(d[5:0]);
  endfunction

  function automatic int slot_of(input int id);
    for (int s = 0; s < n_ins; s++) if (m_id[s] == id) return s;
    return -1;
  endfunction

  function automatic int chain_len(input int b);
    int c = 0;
    for (int s = 0; s < n_ins; s++) if (m_bkt[s] == b) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(input int id, output bit hit, output int port, output int lat, output bit saw_ins);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_key = key_of(id);
    @(negedge clk);
    lkp_valid = 1'b0;
    lat = 0; saw_ins = ins_done;
    while (!lkp_done && lat < 400) begin
      @(negedge clk);
      lat++;
      saw_ins |= ins_done;
    end
    hit = lkp_hit; port = int'(lkp_port);
  endtask

  task automatic check_lookup(input int id, input string req);
    bit h, si; int p, lat, s, pos, b;
    lookup(id, h, p, lat, si);
    s = slot_of(id);
    b = bucket_of(key_of(id));
    if (s >= 0) begin
      pos = 1;
      for (int t = s + 1; t < n_ins; t++) if (m_bkt[t] == b) pos++;
      check(h == 1'b1, req, "hit", int'(h), 1);
      check(p == m_port[s], req, "port", p, m_port[s]);
      check(lat == 1 + pos, "R2/R3", "hit latency", lat, 1 + pos);
    end else begin
      check(h == 1'b0, req, "miss", int'(h), 0);
      check(lat == 1 + chain_len(b), chain_len(b) == 0 ? "R5" : "R4", "miss latency", lat, 1 + chain_len(b));
    end
  endtask

  task automatic insert(input int id, input int port, output bit err);
    int n = 0;
    @(negedge clk);
    ins_valid = 1'b1; ins_key = key_of(id); ins_port = PORT_W'(port);
    @(negedge clk);
    ins_valid = 1'b0;
    while (!ins_done && n < 400) begin @(negedge clk); n++; end
    err = ins_err;
    check(ins_done == 1'b1, "R6", "insert done", int'(ins_done), 1);
  endtask

  task automatic learn(input int id, input int port, input bit exp_err, input string req);
    bit e; int s;
    insert(id, port, e);
    check(e == exp_err, req, "ins_err", int'(e), int'(exp_err));
    s = slot_of(id);
    if (s >= 0) m_port[s] = port;
    else if (!exp_err) begin
      m_id[n_ins] = id; m_bkt[n_ins] = bucket_of(key_of(id)); m_port[n_ins] = port; n_ins++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit h, si; int p, lat, q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !lkp_done && !ins_done && !ins_err, "R1", "idle outputs", int'(busy), 0);
    check_lookup(0, "R1");

    // R10: both requests together, insert dropped
    @(negedge clk);
    lkp_valid = 1'b1; lkp_key = key_of(500);
    ins_valid = 1'b1; ins_key = key_of(500); ins_port = 4'd3;
    @(negedge clk);
    lkp_valid = 1'b0; ins_valid = 1'b0;
    lat = 0; si = 1'b0;
    while (!lkp_done && lat < 400) begin @(negedge clk); lat++; si |= ins_done; end
    check(lkp_hit == 1'b0 && lat == 1, "R10", "lookup taken", lat, 1);
    repeat (4) begin @(negedge clk); si |= ins_done; end
    check(!si, "R10", "insert dropped done", int'(si), 0);
    check_lookup(500, "R10");

    for (int i = 0; i < 32; i++) learn(i, i % 16, 1'b0, "R6");
    for (int i = 1000; i < 1032; i++) check_lookup(i, "R4");

    // R9: stray requests while busy
    @(negedge clk);
    lkp_valid = 1'b1; lkp_key = key_of(3);
    @(negedge clk);
    lkp_key = key_of(1001);
    ins_valid = 1'b1; ins_key = key_of(900); ins_port = 4'd9;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    @(negedge clk);
    lkp_valid = 1'b0; ins_valid = 1'b0;
    q = 0; si = 1'b0;
    while (!lkp_done && q < 400) begin @(negedge clk); q++; si |= ins_done; end
    check(lkp_hit == 1'b1 && int'(lkp_port) == 3, "R9", "first request result", int'(lkp_port), 3);
    lat = 0;
    repeat (6) begin @(negedge clk); lat += int'(lkp_done); si |= ins_done; end
    check(lat == 0 && !si, "R9", "extra done pulses", lat, 0);
    check_lookup(900, "R9");

    for (int i = 32; i < 127; i++) learn(i, (i * 5) % 16, 1'b0, "R6");
    learn(5, 15, 1'b0, "R7");
    learn(127, 2, 1'b0, "R7");
    learn(200, 1, 1'b1, "R8");
    learn(10, 12, 1'b0, "R7");
    check_lookup(5, "R7");
    check_lookup(10, "R7");
    check_lookup(200, "R8");
    check_lookup(127, "R6");
    for (int i = 0; i < 128; i++) check_lookup(i, "R3");
    for (int i = 1000; i < 1064; i++) check_lookup(i, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule